// File: doc/BRIEF.md
# Strap Latch with Test-Clock Divider

This block samples the board-level frequency-select straps at power-good time and decides which of three operating modes the clock generator runs in. Two straps are ordinary binary inputs. The third is a three-level input, and the analog front end delivers it already encoded as a 2-bit code. The block keeps the captured values and passes a compact frequency code to the downstream synthesizer. That code carries the CPU frequency choice and tells the synthesizer whether the 66 MHz-class buffers follow an external input. The latched current-multiplier select is also forwarded.

The mid level of the three-level strap opens two special modes. In the first, every output group is disabled, and each group's output-enable drops so the pad driver can model high impedance. In the second, a single test clock drives all output groups through fixed power-of-two dividers. These dividers share one counter, so all divided outputs start together and stay aligned to test-clock rising edges. In normal mode the group clock ports stay low with their enables high, because the real clocks come from the synthesizer.

Top module: `clkstrap_testdiv`

## Requirements
- R1: Straps and the multiplier select are captured on the first rising edge of `tclk` at which `pwr_good` is low, provided it was high at the edge before. After reset, the first low sample also captures. At every other edge `freq_code` and `mult_q` hold their values.
- R2: `freq_code[1:0]` is the captured `strap_sel`, with 00=66, 01=100, 10=200 and 11=133 MHz for the CPU. `freq_code[2]` is 1 only when the three-level strap was captured high, meaning the 66 MHz buffers follow the external input.
- R3: The three-level code is 00=low and 01=high, and both 10 and 11 mean mid. A mid level is captured as 0 in `freq_code[2]`.
- R4: A mid capture with `strap_sel` equal to 00, 10 or 11 selects the disabled mode. In that mode every `*_oe` is 0, every group clock is 0 and `test_on` is 0.
- R5: A mid capture with `strap_sel` equal to 01 selects test mode. In that mode `test_on` and every `*_oe` are 1, and `ref_clk` follows `tclk`.
- R6: In test mode `cpu_clk` and `usb_clk` run at `tclk`/2, `m66_clk` at `tclk`/4 and `pci_clk` at `tclk`/8. Each changes only just after a rising `tclk` edge.
- R7: The shared divider is zero while test mode is off. In the first cycle after test mode is entered, all divided clocks are low; after k further rising edges they equal bits of k. A capture that keeps test mode does not restart the divider.
- R8: A low or high capture selects normal mode. In normal mode every `*_oe` is 1, all group clocks are 0 and `test_on` is 0.
- R9: While `rst_n` is low, `freq_code` is 0, `mult_q` is 0 and the mode is normal.
- R10: `mult_q` is the `mult_in` value taken at the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock, also the block's sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Qualifying power-good; a low sample after high captures straps |
| strap_trl | input | 2 | Encoded three-level strap: 00 low, 01 high, 1x mid |
| strap_sel | input | 2 | Binary frequency-select straps |
| mult_in | input | 1 | Current-multiplier select strap |
| cpu_clk | output | 1 | CPU group test clock |
| cpu_oe | output | 1 | CPU group output enable |
| m66_clk | output | 1 | 66 MHz-class group test clock |
| m66_oe | output | 1 | 66 MHz-class group output enable |
| pci_clk | output | 1 | PCI group test clock |
| pci_oe | output | 1 | PCI group output enable |
| ref_clk | output | 1 | Reference group test clock |
| ref_oe | output | 1 | Reference group output enable |
| usb_clk | output | 1 | USB/dot group test clock |
| usb_oe | output | 1 | USB/dot group output enable |
| freq_code | output | 3 | Latched code for the synthesizer: external-66 flag, CPU select |
| mult_q | output | 1 | Latched multiplier select |
| test_on | output | 1 | High while test mode is active |

## Verification
The hardest case to reach is a mode change that starts or keeps test mode in the middle of a divider count. Only a power-good high-to-low transition with the right straps makes that happen. The directed part of the stimulus walks through the whole chain: test, then normal, disabled, reserved-disabled and test again. The random part toggles `pwr_good` about once every eight cycles and changes the straps every cycle. It therefore produces repeated test-to-test captures at arbitrary counter phases, as well as straps that change while power-good is high and must be ignored.

// File: rtl/clkstrap_pkg.sv
package clkstrap_pkg;

   typedef enum logic [1:0] {
      MODE_RUN  = 2'd0,
      MODE_OFF  = 2'd1,
      MODE_TEST = 2'd2
   } mode_e;

   localparam logic [1:0] TRL_HIGH = 2'b01;

   // Bit 1 of the three-level code marks the mid level; only mid+01 is test.
   function automatic mode_e decode_mode(input logic [1:0] trl, input logic [1:0] sel);
      if (!trl[1])
         return MODE_RUN;
      if (sel == 2'b01)
         return MODE_TEST;
      return MODE_OFF;
   endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
   import clkstrap_pkg::*;
#(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pg,
   input  logic [1:0]       trl,
   input  logic [SEL_W-1:0] sel,
   input  logic             mult,
   output logic [SEL_W:0]   code_q,
   output logic             mult_q,
   output mode_e            mode_q
);

   logic pg_prev;
   logic take;

   assign take = !pg && pg_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_prev <= 1'b1;
         code_q  <= '0;
         mult_q  <= 1'b0;
         mode_q  <= MODE_RUN;
      end else begin
         pg_prev <= pg;
         if (take) begin
            code_q <= {(trl == TRL_HIGH), sel};
            mult_q <= mult;
            mode_q <= decode_mode(trl, sel[1:0]);
         end
      end
   end

endmodule

// File: rtl/tdiv_counter.sv
module tdiv_counter #(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/out_group.sv
module out_group #(
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned DIV_LOG2 = 1
) (
   input  logic             tclk,
   input  logic [CNT_W-1:0] cnt,
   input  logic             test,
   input  logic             off,
   output logic             clk_o,
   output logic             oe_o
);

   generate
      if (DIV_LOG2 == 0) begin : g_pass
         assign clk_o = tclk & test;
      end else begin : g_div
         assign clk_o = cnt[DIV_LOG2-1] & test;
      end
   endgenerate

   assign oe_o = !off;

endmodule

// File: rtl/clkstrap_testdiv.sv
module clkstrap_testdiv
   import clkstrap_pkg::*;
#(
   parameter int unsigned REF_DIV_LOG2 = 0,
   parameter int unsigned CPU_DIV_LOG2 = 1,
   parameter int unsigned M66_DIV_LOG2 = 2,
   parameter int unsigned PCI_DIV_LOG2 = 3,
   parameter int unsigned USB_DIV_LOG2 = 1
) (
   input  logic       tclk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic [1:0] strap_trl,
   input  logic [1:0] strap_sel,
   input  logic       mult_in,
   output logic       cpu_clk,
   output logic       cpu_oe,
   output logic       m66_clk,
   output logic       m66_oe,
   output logic       pci_clk,
   output logic       pci_oe,
   output logic       ref_clk,
   output logic       ref_oe,
   output logic       usb_clk,
   output logic       usb_oe,
   output logic [2:0] freq_code,
   output logic       mult_q,
   output logic       test_on
);

   localparam int unsigned N_GRP = 5;
   localparam int unsigned GRP_LOG2 [N_GRP] =
      '{REF_DIV_LOG2, CPU_DIV_LOG2, M66_DIV_LOG2, PCI_DIV_LOG2, USB_DIV_LOG2};
   localparam int unsigned MAX_LOG2 =
      (REF_DIV_LOG2 > CPU_DIV_LOG2 ? REF_DIV_LOG2 : CPU_DIV_LOG2) >
      (M66_DIV_LOG2 > PCI_DIV_LOG2 ? M66_DIV_LOG2 : PCI_DIV_LOG2) ?
      (REF_DIV_LOG2 > CPU_DIV_LOG2 ? REF_DIV_LOG2 : CPU_DIV_LOG2) :
      (M66_DIV_LOG2 > PCI_DIV_LOG2 ? M66_DIV_LOG2 : PCI_DIV_LOG2);
   localparam int unsigned TOP_LOG2 = MAX_LOG2 > USB_DIV_LOG2 ? MAX_LOG2 : USB_DIV_LOG2;
   localparam int unsigned CNT_W    = TOP_LOG2 > 0 ? TOP_LOG2 : 1;

   generate
      if (TOP_LOG2 > 16) begin : g_bad_div
         $error("clkstrap_testdiv: divider exponent above 16 is not supported");
      end
   endgenerate

   mode_e            mode_q;
   logic [CNT_W-1:0] div_cnt;
   logic             in_test;
   logic             in_off;
   logic [N_GRP-1:0] gclk;
   logic [N_GRP-1:0] goe;

   strap_capture #(.SEL_W(2)) u_cap (
      .clk    (tclk),
      .rst_n  (rst_n),
      .pg     (pwr_good),
      .trl    (strap_trl),
      .sel    (strap_sel),
      .mult   (mult_in),
      .code_q (freq_code),
      .mult_q (mult_q),
      .mode_q (mode_q)
   );

   assign in_test = (mode_q == MODE_TEST);
   assign in_off  = (mode_q == MODE_OFF);

   tdiv_counter #(.CNT_W(CNT_W)) u_div (
      .clk   (tclk),
      .rst_n (rst_n),
      .run   (in_test),
      .cnt   (div_cnt)
   );

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      out_group #(.CNT_W(CNT_W), .DIV_LOG2(GRP_LOG2[g])) u_grp (
         .tclk  (tclk),
         .cnt   (div_cnt),
         .test  (in_test),
         .off   (in_off),
         .clk_o (gclk[g]),
         .oe_o  (goe[g])
      );
   end

   assign ref_clk = gclk[0];
   assign ref_oe  = goe[0];
   assign cpu_clk = gclk[1];
   assign cpu_oe  = goe[1];
   assign m66_clk = gclk[2];
   assign m66_oe  = goe[2];
   assign pci_clk = gclk[3];
   assign pci_oe  = goe[3];
   assign usb_clk = gclk[4];
   assign usb_oe  = goe[4];
   assign test_on = in_test;

endmodule

// File: rtl/clkstrap_chk.sv
module clkstrap_chk (
   input logic       tclk,
   input logic       rst_n,
   input logic       pwr_good,
   input logic       cpu_clk,
   input logic       cpu_oe,
   input logic       m66_clk,
   input logic       m66_oe,
   input logic       pci_clk,
   input logic       pci_oe,
   input logic       ref_oe,
   input logic       usb_clk,
   input logic       usb_oe,
   input logic [2:0] freq_code,
   input logic       mult_q,
   input logic       test_on
);

   logic pg_seen;

   always_ff @(posedge tclk or negedge rst_n) begin
      if (!rst_n)
         pg_seen <= 1'b1;
      else
         pg_seen <= pwr_good;
   end

   a_r1_hold: assert property (@(posedge tclk) disable iff (!rst_n)
      (pwr_good || !pg_seen) |=> ($stable(freq_code) && $stable(mult_q)));

   a_r4_off_quiet: assert property (@(posedge tclk) disable iff (!rst_n)
      !cpu_oe |-> (!test_on && !m66_oe && !pci_oe && !ref_oe && !usb_oe &&
                   !cpu_clk && !m66_clk && !pci_clk && !usb_clk));

   a_r5_test_enabled: assert property (@(posedge tclk) disable iff (!rst_n)
      test_on |-> (cpu_oe && m66_oe && pci_oe && ref_oe && usb_oe));

   a_r6_half_toggle: assert property (@(posedge tclk) disable iff (!rst_n)
      (test_on && $past(test_on)) |-> (cpu_clk != $past(cpu_clk)));

   a_r7_entry_low: assert property (@(posedge tclk) disable iff (!rst_n)
      $rose(test_on) |-> (!cpu_clk && !m66_clk && !pci_clk && !usb_clk));

   a_r7_aligned: assert property (@(posedge tclk) disable iff (!rst_n)
      (test_on && $rose(pci_clk)) |-> (!m66_clk && !cpu_clk && !usb_clk));

   a_r8_run_low: assert property (@(posedge tclk) disable iff (!rst_n)
      (!test_on && cpu_oe) |-> (!cpu_clk && !m66_clk && !pci_clk && !usb_clk));

endmodule

bind clkstrap_testdiv clkstrap_chk u_chk (.*);

// File: tb/tb_clkstrap_testdiv.sv
module tb_clkstrap_testdiv;

   logic       tclk = 1'b0;
   logic       rst_n;
   logic       pwr_good;
   logic [1:0] strap_trl;
   logic [1:0] strap_sel;
   logic       mult_in;
   logic       cpu_clk, cpu_oe, m66_clk, m66_oe, pci_clk, pci_oe;
   logic       ref_clk, ref_oe, usb_clk, usb_oe, mult_q, test_on;
   logic [2:0] freq_code;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // model: 0 run, 1 off, 2 test
   int         m_mode;
   logic       m_pgp;
   logic [2:0] m_code;
   logic       m_mult;
   logic [2:0] m_cnt;

   always #4 tclk = ~tclk;

   clkstrap_testdiv dut (.*);

   task automatic chk(input string rq, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic int exp_mode(input logic [1:0] trl, input logic [1:0] sel);
      if (!trl[1]) return 0;
      if (sel == 2'b01) return 2;
      return 1;
   endfunction

   function automatic logic [2:0] exp_code(input logic [1:0] trl, input logic [1:0] sel);
      return {(trl == 2'b01), sel};
   endfunction

   task automatic check_all(input string code_rq, input bit hi_phase);
      logic t;
      string crq;
      t   = (m_mode == 2);
      crq = (m_mode == 2) ? ((m_cnt == 0) ? "R7" : "R6") : (m_mode == 1 ? "R4" : "R8");
      chk(code_rq, "freq_code", {5'd0, freq_code}, {5'd0, m_code});
      chk("R10", "mult_q", {7'd0, mult_q}, {7'd0, m_mult});
      chk("R5", "test_on", {7'd0, test_on}, {7'd0, t});
      chk((m_mode == 1) ? "R4" : "R5", "oe",
          {3'd0, cpu_oe, m66_oe, pci_oe, ref_oe, usb_oe},
          (m_mode == 1) ? 8'h00 : 8'h1f);
      chk(crq, "cpu/m66/pci/usb", {4'd0, cpu_clk, m66_clk, pci_clk, usb_clk},
          {4'd0, t & m_cnt[0], t & m_cnt[1], t & m_cnt[2], t & m_cnt[0]});
      chk("R5", "ref_clk", {7'd0, ref_clk}, {7'd0, t & hi_phase});
   endtask

   task automatic tick(input string code_rq);
      @(posedge tclk);
      if (m_mode == 2) m_cnt = m_cnt + 3'd1;
      else             m_cnt = 3'd0;
      if (!pwr_good && m_pgp) begin
         m_code = exp_code(strap_trl, strap_sel);
         m_mult = mult_in;
         m_mode = exp_mode(strap_trl, strap_sel);
      end
      m_pgp = pwr_good;
      #2;
      check_all(code_rq, 1'b1);
      @(negedge tclk);
      #1;
      check_all(code_rq, 1'b0);
   endtask

   task automatic set_in(input logic pg, input logic [1:0] trl, input logic [1:0] sel,
                         input logic mu);
      pwr_good  = pg;
      strap_trl = trl;
      strap_sel = sel;
      mult_in   = mu;
   endtask

   initial begin
      #(64'd8 * 64'd200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n  = 1'b0;
      set_in(1'b1, 2'b00, 2'b00, 1'b0);
      m_mode = 0; m_pgp = 1'b1; m_code = 3'd0; m_mult = 1'b0; m_cnt = 3'd0;
      repeat (3) @(negedge tclk);
      #1;
      check_all("R9", 1'b0);
      rst_n = 1'b1;
      repeat (3) tick("R9");

      // mid + 01: test mode, divider from zero
      set_in(1'b0, 2'b10, 2'b01, 1'b1);
      repeat (20) tick("R2");
      // power-good high: strap changes must be ignored
      set_in(1'b1, 2'b01, 2'b11, 1'b0);
      repeat (6) tick("R1");
      set_in(1'b1, 2'b00, 2'b10, 1'b1);
      repeat (3) tick("R1");
      // high strap: normal, external-66 flag set
      set_in(1'b0, 2'b01, 2'b10, 1'b1);
      repeat (4) tick("R2");
      set_in(1'b0, 2'b11, 2'b00, 1'b0);
      repeat (3) tick("R1");
      // mid coded as 11 with 00: disabled, mid latched as 0
      set_in(1'b1, 2'b11, 2'b00, 1'b0);
      tick("R3");
      set_in(1'b0, 2'b11, 2'b00, 1'b0);
      repeat (4) tick("R3");
      // reserved mid + 10: disabled
      set_in(1'b1, 2'b10, 2'b10, 1'b1);
      tick("R3");
      set_in(1'b0, 2'b10, 2'b10, 1'b1);
      repeat (4) tick("R3");
      // test entered again from disabled, then re-captured mid-count
      set_in(1'b1, 2'b10, 2'b01, 1'b0);
      tick("R2");
      set_in(1'b0, 2'b10, 2'b01, 1'b0);
      repeat (5) tick("R2");
      set_in(1'b1, 2'b10, 2'b01, 1'b0);
      tick("R2");
      set_in(1'b0, 2'b10, 2'b01, 1'b1);
      repeat (12) tick("R2");

      for (int i = 0; i < 3000; i++) begin
         logic pg;
         pg = pwr_good;
         if (($urandom % 8) == 0) pg = ~pg;
         set_in(pg, 2'($urandom), 2'($urandom), 1'($urandom));
         tick("R2");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule